// File: doc/BRIEF.md
# Supply-Pulse Programming Controller

This block interprets a stream of programming events taken from a sensor's supply line. An analog front end, outside this block, classifies each excursion of the supply as a mid-level pulse or a high-level pulse. It reports each pulse as a one-cycle strobe when the pulse falls. The controller counts mid pulses between high pulses. Those counts choose a programming mode (trial or permanent), choose one of the parameter registers, and then step that register's code up one value at a time.

Each register has two layers. Trial bits are lost at every power cycle. Fuse bits are modelled as sticky flops that keep their value across a power cycle. The value presented downstream is the OR of the two layers.

In permanent mode the controller requests exactly one fuse per power cycle, as a single strobe carrying a register number and a bit index. Once the global lock fuse is set, the controller refuses all further programming.

Top module: `pulse_prog_ctrl`

## Requirements
- R1: After `rst_n` is asserted (a power cycle), every register output equals its fuse bits: all zero on a fresh part. `blow_stb` is low, and `locked` reflects only the lock fuse.
- R2: In the idle-after-power-up state, mid pulses have no effect. One high pulse opens mode selection.
- R3: During mode selection, mid pulses count a key. Key 1 chooses permanent mode and key 2 chooses trial mode. The first high pulse closes the key, and a second high pulse opens register selection.
- R4: During register selection, the mid-pulse count names the register. Key 1 is the 9-bit sensitivity register (bit 8 picks the coarse duty range). Key 2 is the 9-bit fine duty register (bit 8 flips the trim direction). Key 3 is the 5-bit carrier register (bit 4 is its coarse range). Key 4 is an empty register. Key 5 is the 10-bit calibration/lock register (bit 4 enables calibration, bit 9 is the lock). A high pulse then opens code addressing.
- R5: During code addressing, each mid pulse adds one to the code. The code saturates at the register's all-ones value: 511, 511, 31, 0 or 1023.
- R6: Each register output is the OR of its fuse bits and its trial bits, and the register selected during addressing shows the live code.
- R7: In trial mode, a high pulse during addressing returns to register selection and keeps the addressed value, so several registers can hold trial values at the same time.
- R8: In permanent mode, a high pulse during addressing produces at most one `blow_stb` cycle. The strobe carries `blow_reg` (the register key) and `blow_bit`. Every later pulse is then ignored until the next power cycle.
- R9: Fuse bits survive a power cycle and trial bits do not. Fuse bits blown in separate power cycles accumulate by OR.
- R10: A blow request is rejected, with no strobe, when the code minus the fuses already blown has zero bits set or more than one bit set.
- R11: Entering code addressing loads the register's fuse bits as the starting code, so counting continues from the blown value.
- R12: A mode key other than 1 or 2, or a register key of 0 or above 5, parks the controller until the next power cycle.
- R13: When bit 9 of the calibration/lock register is blown, `locked` is high and every later programming sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-cycle reset; clears logic and trial bits |
| fab_rst_n | input | 1 | Synchronous active-low reset of the fuse model (virgin part) |
| mid_evt | input | 1 | One-cycle strobe: a mid-level pulse has ended |
| high_evt | input | 1 | One-cycle strobe: a high-level pulse has ended |
| sens_q | output | 9 | Effective sensitivity register (key 1) |
| duty_fine_q | output | 9 | Effective fine duty register (key 2) |
| carrier_q | output | 5 | Effective carrier register (key 3) |
| cal_lock_q | output | 10 | Effective calibration/lock register (key 5) |
| blow_stb | output | 1 | One-cycle fuse-blow request |
| blow_reg | output | 3 | Register key of the requested fuse |
| blow_bit | output | 4 | Bit index of the requested fuse |
| locked | output | 1 | Lock fuse is blown |

## Verification
The assertions assume that `mid_evt` and `high_evt` are already-classified single-cycle strobes. The two are never high in the same cycle, and each is followed by at least one quiet cycle. The bench keeps within these assumptions by driving every pulse through one task that raises a single strobe for one cycle and then idles for one cycle.

The fuse-model checks also assume that `fab_rst_n` is asserted only once, at time zero. The bench never touches it again, so only `rst_n` stands in for power cycles.

// File: rtl/prog_pkg.sv
// Shared constants, register layout and state encoding for the
// supply-pulse programming controller.
// Assumes register keys run 1..NUM_REGS and map to slot key-1.
package prog_pkg;
    localparam int CODE_W        = 10;
    localparam int NUM_REGS      = 5;
    localparam int KEY_W         = 3;
    localparam int SLOT_W        = $clog2(NUM_REGS);
    localparam int BIT_W         = $clog2(CODE_W);
    localparam int LOCK_SLOT     = 4;
    localparam int LOCK_BIT      = 9;
    localparam int MODE_KEY_BLOW = 1;
    localparam int MODE_KEY_TRY  = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_MODE,
        ST_MODE_ARM,
        ST_PARAM,
        ST_FIELD,
        ST_BLOW,
        ST_HALT
    } prog_state_e;

    // Implemented bits of each register slot; slot 3 is the empty register.
    function automatic code_t slot_mask(input logic [SLOT_W-1:0] slot);
        case (slot)
            3'd0:    return 10'h1FF;
            3'd1:    return 10'h1FF;
            3'd2:    return 10'h01F;
            3'd4:    return 10'h3FF;
            default: return 10'h000;
        endcase
    endfunction
endpackage

// File: rtl/prog_key_cnt.sv
// Saturating counter of mid pulses that forms a mode or register key.
// Assumes clr and inc are single-cycle requests from the sequencer.
module prog_key_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // Count up on inc, hold at the maximum, clear with priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + W'(1);
        end
    end

    // R3
    key_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/prog_seq.sv
// Programming sequencer: walks the mode, register and code phases from
// classified pulse strobes, owns the live code, issues trial writes
// and single-bit blow requests.
// Assumes mid_evt and high_evt are never high together.
module prog_seq
    import prog_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             mid_evt,
    input  logic                             high_evt,
    input  logic                             locked,
    input  logic [KEY_W-1:0]                 key,
    input  logic [NUM_REGS-1:0][CODE_W-1:0]  fuse_all,
    output logic                             key_clr,
    output logic                             key_inc,
    output logic                             trial_we,
    output logic [SLOT_W-1:0]                trial_slot,
    output code_t                            trial_val,
    output logic                             blow_stb,
    output logic [SLOT_W-1:0]                blow_slot,
    output logic [BIT_W-1:0]                 blow_bit
);
    prog_state_e       state;
    logic              mode_blow;
    logic [SLOT_W-1:0] sel;
    code_t             code;

    logic [SLOT_W-1:0] key_slot;
    logic              key_ok;
    code_t             fuse_key;
    code_t             fuse_sel;
    code_t             code_step;
    code_t             new_bits;
    logic              blow_ok;

    assign key_slot = SLOT_W'(key - KEY_W'(1));
    assign key_ok   = (key >= KEY_W'(1)) && (key <= KEY_W'(NUM_REGS));

    // Pick the fuse word of the keyed slot and of the selected slot.
    always_comb begin
        fuse_key = '0;
        fuse_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (key_slot == SLOT_W'(i)) fuse_key = fuse_all[i];
            if (sel == SLOT_W'(i))      fuse_sel = fuse_all[i];
        end
    end

    // Next code value: one step up, held at the register's maximum.
    assign code_step = (code == slot_mask(sel)) ? code : code + CODE_W'(1);

    // Bits the blow request would add beyond the fuses already set.
    assign new_bits = code & ~fuse_sel & slot_mask(sel);
    assign blow_ok  = (new_bits != '0) && ((new_bits & (new_bits - CODE_W'(1))) == '0);

    // Key counter control: count in the key phases, clear on every high pulse.
    assign key_inc = mid_evt && (state == ST_MODE || state == ST_PARAM);
    assign key_clr = high_evt || (state == ST_INIT);

    // Trial write: preload on entering addressing, live step on each mid pulse.
    always_comb begin
        trial_we   = 1'b0;
        trial_slot = sel;
        trial_val  = code_step;
        if (state == ST_PARAM && high_evt && key_ok) begin
            trial_we   = 1'b1;
            trial_slot = key_slot;
            trial_val  = fuse_key;
        end else if (state == ST_FIELD && mid_evt) begin
            trial_we   = 1'b1;
        end
    end

    // Blow request: a single new bit, raised for the one cycle in ST_BLOW.
    assign blow_stb  = (state == ST_BLOW) && blow_ok;
    assign blow_slot = sel;
    always_comb begin
        blow_bit = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (new_bits[i]) blow_bit = BIT_W'(i);
        end
    end

    // Phase sequencing of the programming protocol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_INIT;
            mode_blow <= 1'b0;
            sel       <= '0;
            code      <= '0;
        end else begin
            case (state)
                ST_INIT: begin
                    if (high_evt && !locked) state <= ST_MODE;
                end
                ST_MODE: begin
                    if (high_evt) begin
                        if (key == KEY_W'(MODE_KEY_BLOW)) begin
                            mode_blow <= 1'b1;
                            state     <= ST_MODE_ARM;
                        end else if (key == KEY_W'(MODE_KEY_TRY)) begin
                            mode_blow <= 1'b0;
                            state     <= ST_MODE_ARM;
                        end else begin
                            state     <= ST_HALT;
                        end
                    end
                end
                ST_MODE_ARM: begin
                    if (high_evt) state <= ST_PARAM;
                end
                ST_PARAM: begin
                    if (high_evt) begin
                        if (key_ok) begin
                            sel   <= key_slot;
                            code  <= fuse_key;
                            state <= ST_FIELD;
                        end else begin
                            state <= ST_HALT;
                        end
                    end
                end
                ST_FIELD: begin
                    if (mid_evt) begin
                        code <= code_step;
                    end else if (high_evt) begin
                        state <= mode_blow ? ST_BLOW : ST_PARAM;
                    end
                end
                ST_BLOW:  state <= ST_HALT;
                default:  state <= ST_HALT;
            endcase
        end
    end

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT));
    // R8
    single_blow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blow_stb |=> !blow_stb);
    // R5
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIELD) |-> ((code & ~slot_mask(sel)) == '0));
    // R13
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && state == ST_INIT) |=> (state == ST_INIT));
endmodule

// File: rtl/prog_bank.sv
// Register bank: per slot, a trial word cleared at power cycle and a
// sticky fuse word cleared only by the fuse-model reset; exposes the
// masked OR of both and the lock status.
// Assumes blow_bit always names a bit inside the slot's width.
module prog_bank
    import prog_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             fab_rst_n,
    input  logic                             trial_we,
    input  logic [SLOT_W-1:0]                trial_slot,
    input  code_t                            trial_val,
    input  logic                             blow_stb,
    input  logic [SLOT_W-1:0]                blow_slot,
    input  logic [BIT_W-1:0]                 blow_bit,
    output logic [NUM_REGS-1:0][CODE_W-1:0]  fuse_all,
    output logic [NUM_REGS-1:0][CODE_W-1:0]  eff_all,
    output logic                             locked
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        code_t trial_r;
        code_t fuse_r;

        // Trial word: written by the sequencer, lost at every power cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trial_r <= '0;
            end else if (trial_we && trial_slot == SLOT_W'(g)) begin
                trial_r <= trial_val;
            end
        end

        // Fuse word: one bit set per blow strobe, never cleared by rst_n.
        always_ff @(posedge clk) begin
            if (!fab_rst_n) begin
                fuse_r <= '0;
            end else if (blow_stb && blow_slot == SLOT_W'(g)) begin
                fuse_r <= fuse_r | (CODE_W'(1) << blow_bit);
            end
        end

        assign fuse_all[g] = fuse_r;
        assign eff_all[g]  = (fuse_r | trial_r) & slot_mask(SLOT_W'(g));

        // R9
        fuse_keep_chk: assert property (@(posedge clk) disable iff (!fab_rst_n)
            1'b1 |=> ((fuse_r & $past(fuse_r)) == $past(fuse_r)));
        // R10
        fresh_fuse_chk: assert property (@(posedge clk) disable iff (!fab_rst_n || !rst_n)
            (blow_stb && blow_slot == SLOT_W'(g)) |-> ((fuse_r & (CODE_W'(1) << blow_bit)) == '0));
    end

    assign locked = fuse_all[LOCK_SLOT][LOCK_BIT];
endmodule

// File: rtl/pulse_prog_ctrl.sv
// Top of the supply-pulse programming controller: key counter,
// sequencer and register bank, with register outputs cut to width.
// Assumes pulse strobes are pre-classified and single-cycle.
module pulse_prog_ctrl
    import prog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fab_rst_n,
    input  logic        mid_evt,
    input  logic        high_evt,
    output logic [8:0]  sens_q,
    output logic [8:0]  duty_fine_q,
    output logic [4:0]  carrier_q,
    output logic [9:0]  cal_lock_q,
    output logic        blow_stb,
    output logic [2:0]  blow_reg,
    output logic [3:0]  blow_bit,
    output logic        locked
);
    logic [KEY_W-1:0]                key;
    logic                            key_clr;
    logic                            key_inc;
    logic                            trial_we;
    logic [SLOT_W-1:0]               trial_slot;
    code_t                           trial_val;
    logic [SLOT_W-1:0]               blow_slot;
    logic [NUM_REGS-1:0][CODE_W-1:0] fuse_all;
    logic [NUM_REGS-1:0][CODE_W-1:0] eff_all;
    logic                            unused_bits;

    prog_key_cnt #(.W(KEY_W)) u_key (
        .clk (clk),
        .rst_n (rst_n),
        .clr (key_clr),
        .inc (key_inc),
        .cnt (key)
    );

    prog_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mid_evt    (mid_evt),
        .high_evt   (high_evt),
        .locked     (locked),
        .key        (key),
        .fuse_all   (fuse_all),
        .key_clr    (key_clr),
        .key_inc    (key_inc),
        .trial_we   (trial_we),
        .trial_slot (trial_slot),
        .trial_val  (trial_val),
        .blow_stb   (blow_stb),
        .blow_slot  (blow_slot),
        .blow_bit   (blow_bit)
    );

    prog_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .fab_rst_n  (fab_rst_n),
        .trial_we   (trial_we),
        .trial_slot (trial_slot),
        .trial_val  (trial_val),
        .blow_stb   (blow_stb),
        .blow_slot  (blow_slot),
        .blow_bit   (blow_bit),
        .fuse_all   (fuse_all),
        .eff_all    (eff_all),
        .locked     (locked)
    );

    assign sens_q      = eff_all[0][8:0];
    assign duty_fine_q = eff_all[1][8:0];
    assign carrier_q   = eff_all[2][4:0];
    assign cal_lock_q  = eff_all[4][9:0];
    assign blow_reg    = blow_slot + 3'd1;
    assign unused_bits = ^{eff_all[0][9], eff_all[1][9], eff_all[2][9:5], eff_all[3]};

    // R4
    blow_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blow_stb |-> (blow_reg != 3'd4 && blow_reg >= 3'd1 && blow_reg <= 3'd5));
endmodule

// File: tb/pulse_prog_ctrl_bench.sv
module pulse_prog_ctrl_bench;
    localparam int CLK_P    = 10;
    localparam int WATCHDOG = 200000;
    localparam int NVEC     = 5;
    // {key[2:0], mid count[10:0], expected value[9:0]}, trial mode
    localparam logic [23:0] VEC [NVEC] = '{
        {3'd1, 11'd5,   10'd5},
        {3'd2, 11'd300, 10'd300},
        {3'd3, 11'd40,  10'd31},
        {3'd5, 11'd16,  10'd16},
        {3'd1, 11'd600, 10'd511}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fab_rst_n = 1'b0;
    logic mid_evt = 1'b0;
    logic high_evt = 1'b0;
    logic [8:0] sens_q;
    logic [8:0] duty_fine_q;
    logic [4:0] carrier_q;
    logic [9:0] cal_lock_q;
    logic       blow_stb;
    logic [2:0] blow_reg;
    logic [3:0] blow_bit;
    logic       locked;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    int last_reg = 0;
    int last_bit = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pulse_prog_ctrl u_pulse_prog_ctrl (
        .clk (clk), .rst_n (rst_n), .fab_rst_n (fab_rst_n),
        .mid_evt (mid_evt), .high_evt (high_evt),
        .sens_q (sens_q), .duty_fine_q (duty_fine_q), .carrier_q (carrier_q),
        .cal_lock_q (cal_lock_q), .blow_stb (blow_stb), .blow_reg (blow_reg),
        .blow_bit (blow_bit), .locked (locked)
    );

    // Blow strobe monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && blow_stb) begin
            stb_cnt  <= stb_cnt + 1;
            last_reg <= int'(blow_reg);
            last_bit <= int'(blow_bit);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_mid(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) mid_evt = 1'b1;
            @(negedge clk) mid_evt = 1'b0;
        end
    endtask

    task automatic pulse_high(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) high_evt = 1'b1;
            @(negedge clk) high_evt = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic power_cycle();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic open_session(input int mode_key);
        pulse_high(1);
        pulse_mid(mode_key);
        pulse_high(2);
    endtask

    task automatic address(input int key, input int n);
        pulse_mid(key);
        pulse_high(1);
        pulse_mid(n);
    endtask

    function automatic int reg_by_key(input int key);
        case (key)
            1: return int'(sens_q);
            2: return int'(duty_fine_q);
            3: return int'(carrier_q);
            5: return int'(cal_lock_q);
            default: return -1;
        endcase
    endfunction

    initial begin
        #(CLK_P * WATCHDOG);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fab_rst_n = 1'b1;
        settle();

        // R1: fresh part after reset
        chk("R1 sens", int'(sens_q), 0);
        chk("R1 duty", int'(duty_fine_q), 0);
        chk("R1 carrier", int'(carrier_q), 0);
        chk("R1 cal_lock", int'(cal_lock_q), 0);
        chk("R1 locked", int'(locked), 0);
        chk("R1 strobe", stb_cnt, 0);

        // R2: mids before the first high are ignored; R3 trial key 2
        pulse_mid(3);
        settle();
        chk("R2 idle mids", int'(carrier_q), 0);
        open_session(2);
        address(3, 1);
        pulse_high(1);
        settle();
        chk("R2 R3 carrier", int'(carrier_q), 1);
        power_cycle();

        // R5 R7: table of trial addressing, all in one session
        open_session(2);
        for (int v = 0; v < NVEC; v++) begin
            address(int'(VEC[v][23:21]), int'(VEC[v][20:10]));
            pulse_high(1);
            settle();
            chk($sformatf("R5 R7 vec%0d", v), reg_by_key(int'(VEC[v][23:21])), int'(VEC[v][9:0]));
        end
        chk("R7 duty kept", int'(duty_fine_q), 300);
        chk("R7 carrier kept", int'(carrier_q), 31);

        // R9: trial bits vanish at power cycle
        power_cycle();
        chk("R9 sens clear", int'(sens_q), 0);
        chk("R9 duty clear", int'(duty_fine_q), 0);

        // R8: blow code 4 in register 2
        open_session(1);
        address(2, 4);
        pulse_high(1);
        settle();
        chk("R8 strobe count", stb_cnt, 1);
        chk("R8 reg", last_reg, 2);
        chk("R8 bit", last_bit, 2);
        chk("R6 duty", int'(duty_fine_q), 4);
        // R8: controller parked, later sequence ignored
        open_session(2);
        address(3, 5);
        pulse_high(1);
        settle();
        chk("R8 parked carrier", int'(carrier_q), 0);
        chk("R8 parked strobe", stb_cnt, 1);

        // R9: fuse survives
        power_cycle();
        chk("R9 fuse kept", int'(duty_fine_q), 4);

        // R11: preload from fuse, one more step gives 5, blows bit 0
        open_session(1);
        address(2, 1);
        pulse_high(1);
        settle();
        chk("R11 strobe", stb_cnt, 2);
        chk("R11 bit", last_bit, 0);
        power_cycle();
        chk("R9 fuse OR", int'(duty_fine_q), 5);

        // R10: two new bits rejected
        open_session(1);
        address(3, 3);
        settle();
        chk("R6 live code", int'(carrier_q), 3);
        pulse_high(1);
        settle();
        chk("R10 multi strobe", stb_cnt, 2);
        power_cycle();
        chk("R10 multi carrier", int'(carrier_q), 0);
        // R10: no new bit rejected
        open_session(1);
        address(2, 0);
        pulse_high(1);
        settle();
        chk("R10 zero strobe", stb_cnt, 2);
        power_cycle();

        // R12: bad mode key parks
        open_session(3);
        address(1, 7);
        pulse_high(1);
        settle();
        chk("R12 mode key", int'(sens_q), 0);
        power_cycle();
        // R12: register key 6 parks
        open_session(2);
        address(6, 4);
        pulse_high(1);
        address(1, 2);
        pulse_high(1);
        settle();
        chk("R12 reg key", int'(sens_q), 0);
        power_cycle();
        // R4: empty register key 4 returns normally
        open_session(2);
        address(4, 3);
        pulse_high(1);
        address(3, 2);
        pulse_high(1);
        settle();
        chk("R4 null reg", int'(carrier_q), 2);
        power_cycle();

        // R13: blow lock bit 9 of register 5
        open_session(1);
        address(5, 512);
        pulse_high(1);
        settle();
        chk("R13 strobe", stb_cnt, 3);
        chk("R13 reg", last_reg, 5);
        chk("R13 bit", last_bit, 9);
        chk("R13 locked", int'(locked), 1);
        chk("R13 cal_lock", int'(cal_lock_q), 512);
        power_cycle();
        chk("R13 locked after cycle", int'(locked), 1);
        open_session(2);
        address(3, 4);
        pulse_high(1);
        settle();
        chk("R13 ignored", int'(carrier_q), 0);
        chk("R13 no strobe", stb_cnt, 3);
        chk("R9 duty after lock", int'(duty_fine_q), 5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule